// File: doc/BRIEF.md
# Self-Timed Program Cycle Engine with Ready/Busy Status

This block sits behind a serial memory front end. Once that front end has seen a complete, correctly framed modify instruction, it hands the block a request: write one location, erase one location, erase the whole array, or fill the whole array with one value. The block then runs a program cycle of fixed length, counted in system clocks, on its own storage array. The serial clock plays no part: it may stop or keep toggling for the whole cycle.

A request is taken only at the clock where chip select is seen falling, and only if the front end has the request marked valid, the write-enable latch is set, and no cycle is already running. A write runs as two halves. The first half clears the target to all ones. The second half loads the new value. The two erase operations finish their work at the end of the first half and then wait out the rest of the cycle.

The status is given on the serial data-out line, and only while chip select is high. The line reads 0 while a cycle runs and 1 once the cycle is over. The ready level stays until chip select drops or a new start bit is decoded. Status shows only if chip select rose after staying low for a minimum number of clocks.

Top module: `prog_cycle_engine`

## Requirements
- R1: After reset the block is not busy, does not drive data-out, and every array location reads all ones.
- R2: A request is taken only in the clock where chip select falls (it was high at the previous clock and is low now) with `req_valid` high. A `req_valid` pulse while chip select stays high does nothing. Operation codes on `req_op`: 0 write, 1 erase one, 2 erase all, 3 write all.
- R3: Erase-one sets the addressed location to all ones and leaves every other location unchanged.
- R4: Write first clears the addressed location to all ones after TW_CYCLES/2 clocks. It then holds the supplied data once the cycle ends.
- R5: Erase-all sets every location to all ones.
- R6: Write-all loads the supplied data into every location.
- R7: While a cycle runs and status is enabled, `dout_en` is 1 and `dout` is 0.
- R8: After a cycle completes, with chip select high and status enabled, `dout_en` and `dout` are 1. They stay so until chip select falls or `start_bit` pulses.
- R9: Status is driven only during a chip-select high period that began after chip select had been low for at least GAP_CYCLES clocks. Otherwise `dout_en` stays 0.
- R10: A request that arrives while a cycle runs is dropped. A request that arrives with `wen` low is dropped.
- R11: `busy` stays high for exactly TW_CYCLES clocks per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, already synchronised |
| start_bit | input | 1 | One-clock pulse: front end decoded a start bit |
| wen | input | 1 | Write-enable latch state |
| req_valid | input | 1 | Pending request is correctly framed |
| req_op | input | 2 | Modify operation code |
| req_addr | input | ADDR_W | Target location |
| req_data | input | DATA_W | Data for write and write-all |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Array read data (combinational) |
| busy | output | 1 | Program cycle in progress |
| dout | output | 1 | Status level on the data-out line |
| dout_en | output | 1 | Data-out drive enable |

## Verification
The hardest state to reach is the middle of a write, after the automatic clear and before the new value lands. The bench issues a write over a location that holds known data. It reads that location through the read port at a clock counted from the chip-select fall, first before the clear and then just after the half-cycle point, and expects the old value and then all ones. A second hard case is a request delivered while a cycle is already running. The bench frames one inside the busy window, then checks that the array and the busy length show no trace of it.

// File: rtl/pce_pkg.sv
package pce_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_ERASE = 2'd1,
        OP_ERAL  = 2'd2,
        OP_WRAL  = 2'd3
    } mod_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CLEAR = 2'd1,
        PH_LOAD  = 2'd2
    } phase_e;

    // Array update strobes produced by the timer for the storage.
    typedef struct packed {
        logic clr;   // set targets to all ones
        logic load;  // put latched data into targets
        logic all;   // targets are every location
    } commit_t;

    function automatic logic op_global(mod_op_e op);
        return (op == OP_ERAL) || (op == OP_WRAL);
    endfunction

    function automatic logic op_loads(mod_op_e op);
        return (op == OP_WRITE) || (op == OP_WRAL);
    endfunction

endpackage

// File: rtl/pce_sel_track.sv
module pce_sel_track
    import pce_pkg::*;
#(
    parameter int GAP_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic start_bit,
    input  logic busy,
    input  logic done,
    output logic cs_fall,
    output logic dout,
    output logic dout_en
);
    localparam int GAP_W = $clog2(GAP_CYCLES + 1);
    localparam logic [GAP_W-1:0] GAP_MAX = GAP_W'(GAP_CYCLES);

    logic             cs_q;
    logic [GAP_W-1:0] low_cnt;
    logic             sel_ok;
    logic             rdy;
    logic             cs_rise;

    assign cs_fall = cs_q && !cs;
    assign cs_rise = !cs_q && cs;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q    <= 1'b0;
            low_cnt <= GAP_MAX;
            sel_ok  <= 1'b0;
            rdy     <= 1'b0;
        end else begin
            cs_q <= cs;
            if (cs) begin
                low_cnt <= '0;
            end else if (low_cnt != GAP_MAX) begin
                low_cnt <= low_cnt + 1'b1;
            end
            if (cs_rise) begin
                sel_ok <= (low_cnt == GAP_MAX);
            end else if (cs_fall) begin
                sel_ok <= 1'b0;
            end
            if (done) begin
                rdy <= 1'b1;
            end else if (cs_fall || (start_bit && !busy)) begin
                rdy <= 1'b0;
            end
        end
    end

    assign dout_en = cs_q && sel_ok && (busy || rdy);
    assign dout    = dout_en && !busy;

endmodule

// File: rtl/pce_timer.sv
module pce_timer
    import pce_pkg::*;
#(
    parameter int TW_CYCLES = 625000
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    launch,
    input  mod_op_e op,
    output logic    busy,
    output logic    done,
    output commit_t ctl
);
    localparam int CNT_W     = (TW_CYCLES > 2) ? $clog2(TW_CYCLES) : 1;
    localparam int CLEAR_LEN = TW_CYCLES / 2;
    localparam logic [CNT_W-1:0] CLEAR_END = CNT_W'(CLEAR_LEN - 1);
    localparam logic [CNT_W-1:0] CYCLE_END = CNT_W'(TW_CYCLES - 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    mod_op_e          op_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            op_q  <= OP_WRITE;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (launch) begin
                        phase <= PH_CLEAR;
                        cnt   <= '0;
                        op_q  <= op;
                    end
                end
                PH_CLEAR: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CLEAR_END) phase <= PH_LOAD;
                end
                PH_LOAD: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CYCLE_END) phase <= PH_IDLE;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign done     = (phase == PH_LOAD) && (cnt == CYCLE_END);
    assign ctl.clr  = (phase == PH_CLEAR) && (cnt == CLEAR_END);
    assign ctl.load = done && op_loads(op_q);
    assign ctl.all  = op_global(op_q);

endmodule

// File: rtl/pce_array.sv
module pce_array
    import pce_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    input  commit_t           ctl,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            data_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            if (launch) begin
                addr_q <= addr;
                data_q <= data;
            end
            for (int i = 0; i < DEPTH; i++) begin
                if (ctl.all || (addr_q == ADDR_W'(i))) begin
                    if (ctl.clr)       mem[i] <= '1;
                    else if (ctl.load) mem[i] <= data_q;
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/prog_cycle_engine.sv
module prog_cycle_engine
    import pce_pkg::*;
#(
    parameter int ADDR_W     = 6,
    parameter int DATA_W     = 8,
    parameter int TW_CYCLES  = 625000,
    parameter int GAP_CYCLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              start_bit,
    input  logic              wen,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              dout,
    output logic              dout_en
);
    logic    cs_fall;
    logic    done;
    logic    launch;
    commit_t ctl;

    assign launch = cs_fall && req_valid && wen && !busy;

    pce_sel_track #(.GAP_CYCLES(GAP_CYCLES)) u_sel (
        .clk(clk), .rst(rst), .cs(cs), .start_bit(start_bit),
        .busy(busy), .done(done), .cs_fall(cs_fall),
        .dout(dout), .dout_en(dout_en)
    );

    pce_timer #(.TW_CYCLES(TW_CYCLES)) u_tmr (
        .clk(clk), .rst(rst), .launch(launch), .op(mod_op_e'(req_op)),
        .busy(busy), .done(done), .ctl(ctl)
    );

    pce_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst(rst), .launch(launch), .addr(req_addr),
        .data(req_data), .ctl(ctl), .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: rtl/pce_chk.sv
module pce_chk #(
    parameter int TW_CYCLES = 625000
) (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic start_bit,
    input logic wen,
    input logic req_valid,
    input logic busy,
    input logic dout,
    input logic dout_en
);
    int bcnt;

    always_ff @(posedge clk) begin
        if (rst || !busy) bcnt <= 0;
        else              bcnt <= bcnt + 1;
    end

    assert_start_on_fall_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (!$past(cs) && $past(req_valid) && $past(wen)));

    assert_busy_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && dout_en) |-> !dout);

    assert_ready_holds_R8: assert property (@(posedge clk) disable iff (rst)
        (dout_en && dout && cs && !start_bit) |=> (dout_en && dout));

    assert_status_when_selected_R9: assert property (@(posedge clk) disable iff (rst)
        dout_en |-> $past(cs));

    assert_wen_blocks_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !wen) |=> !busy);

    assert_cycle_length_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(bcnt) == TW_CYCLES - 1));

    assert_no_data_undriven_R9: assert property (@(posedge clk) disable iff (rst)
        !dout_en |-> !dout);

endmodule

bind prog_cycle_engine pce_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .cs(cs), .start_bit(start_bit), .wen(wen),
    .req_valid(req_valid), .busy(busy), .dout(dout), .dout_en(dout_en)
);

// File: tb/tb_prog_cycle_engine.sv
module tb_prog_cycle_engine;
    localparam int AW  = 6;
    localparam int DW  = 8;
    localparam int TW  = 20;
    localparam int GAP = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst;
    logic          cs, start_bit, wen, req_valid;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr, rd_addr;
    logic [DW-1:0] req_data, rd_data;
    logic          busy, dout, dout_en;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    prog_cycle_engine #(.ADDR_W(AW), .DATA_W(DW), .TW_CYCLES(TW), .GAP_CYCLES(GAP)) dut (
        .clk(clk), .rst(rst), .cs(cs), .start_bit(start_bit), .wen(wen),
        .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
        .req_data(req_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .dout(dout), .dout_en(dout_en)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [DW-1:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // Frame a request: chip select high for two clocks, then dropped with req_valid.
    // Returns at the negedge right after the falling-edge clock.
    task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d);
        cs = 1'b1;
        step(2);
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1; cs = 1'b0;
        step(1);
        req_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) step(1);
        step(1);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        int ones = 0;
        check(busy == 1'b0, "R1 busy after reset", busy, 0);
        check(dout_en == 1'b0, "R1 dout_en after reset", dout_en, 0);
        for (int i = 0; i < DEPTH; i++) begin
            peek(AW'(i), v);
            if (v == 8'hFF) ones++;
        end
        check(ones == DEPTH, "R1 array all ones", ones, DEPTH);
    endtask

    task automatic t_write_two_phase();
        logic [DW-1:0] v;
        int len;
        issue(2'd0, 6'd9, 8'h3C);
        wait_idle();
        peek(6'd9, v);
        check(v == 8'h3C, "R4 write result", v, 8'h3C);
        // second write over known data: watch the clear half
        issue(2'd0, 6'd9, 8'hA5);
        check(busy == 1'b1, "R2 taken on cs fall", busy, 1);
        step(1);
        peek(6'd9, v);
        check(v == 8'h3C, "R4 old data before clear", v, 8'h3C);
        step(TW/2 - 1);
        peek(6'd9, v);
        check(v == 8'hFF, "R4 cleared at half cycle", v, 8'hFF);
        check(busy == 1'b1, "R4 still busy after clear", busy, 1);
        len = TW/2 + 1;
        while (busy) begin step(1); len++; end
        check(len == TW + 1, "R11 busy length", len, TW + 1);
        peek(6'd9, v);
        check(v == 8'hA5, "R4 final data", v, 8'hA5);
    endtask

    task automatic t_erase_one();
        logic [DW-1:0] v;
        issue(2'd0, 6'd4, 8'h11); wait_idle();
        issue(2'd0, 6'd5, 8'h22); wait_idle();
        issue(2'd1, 6'd4, 8'h00); wait_idle();
        peek(6'd4, v);
        check(v == 8'hFF, "R3 erased location", v, 8'hFF);
        peek(6'd5, v);
        check(v == 8'h22, "R3 neighbour kept", v, 8'h22);
    endtask

    task automatic t_status();
        issue(2'd0, 6'd20, 8'h55);
        step(GAP + 1);
        cs = 1'b1;
        step(1);
        check(dout_en == 1'b1, "R7 status driven while busy", dout_en, 1);
        check(dout == 1'b0, "R7 busy reads zero", dout, 0);
        cs = 1'b0;
        wait_idle();
        step(GAP);
        cs = 1'b1;
        step(1);
        check(dout_en && dout, "R8 ready shown", {dout_en, dout}, 3);
        step(5);
        check(dout_en && dout, "R8 ready held", {dout_en, dout}, 3);
        start_bit = 1'b1;
        step(1);
        start_bit = 1'b0;
        step(1);
        check(dout_en == 1'b0, "R8 start bit clears ready", dout_en, 0);
        cs = 1'b0;
        step(GAP + 1);
    endtask

    task automatic t_gap();
        issue(2'd0, 6'd21, 8'h66);
        cs = 1'b1;
        step(2);
        check(dout_en == 1'b0, "R9 short gap no status", dout_en, 0);
        cs = 1'b0;
        step(GAP);
        cs = 1'b1;
        step(1);
        check(dout_en == 1'b1 && dout == 1'b0, "R9 full gap status busy", {dout_en, dout}, 2);
        cs = 1'b0;
        wait_idle();
        step(GAP);
    endtask

    task automatic t_drops();
        logic [DW-1:0] v;
        int len;
        wen = 1'b0;
        issue(2'd0, 6'd30, 8'h77);
        step(2);
        check(busy == 1'b0, "R10 wen low not busy", busy, 0);
        peek(6'd30, v);
        check(v == 8'hFF, "R10 wen low array kept", v, 8'hFF);
        wen = 1'b1;
        cs = 1'b1;
        step(1);
        req_op = 2'd0; req_addr = 6'd31; req_data = 8'h44; req_valid = 1'b1;
        step(1);
        req_valid = 1'b0;
        step(2);
        check(busy == 1'b0, "R2 valid without fall ignored", busy, 0);
        cs = 1'b0;
        step(GAP);
        issue(2'd1, 6'd32, 8'h00);
        len = 1;
        issue(2'd0, 6'd33, 8'h99);
        len += 3;
        while (busy) begin step(1); len++; end
        check(len == TW + 1, "R10 busy not extended", len, TW + 1);
        step(TW + 4);
        peek(6'd33, v);
        check(v == 8'hFF, "R10 request while busy dropped", v, 8'hFF);
    endtask

    task automatic t_global();
        logic [DW-1:0] v;
        int hits = 0;
        issue(2'd3, 6'd0, 8'h5A); wait_idle();
        for (int i = 0; i < DEPTH; i++) begin
            peek(AW'(i), v);
            if (v == 8'h5A) hits++;
        end
        check(hits == DEPTH, "R6 write-all", hits, DEPTH);
        hits = 0;
        issue(2'd2, 6'd7, 8'h00); wait_idle();
        for (int i = 0; i < DEPTH; i++) begin
            peek(AW'(i), v);
            if (v == 8'hFF) hits++;
        end
        check(hits == DEPTH, "R5 erase-all", hits, DEPTH);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cs = 1'b0; start_bit = 1'b0; wen = 1'b1; req_valid = 1'b0;
        req_op = 2'd0; req_addr = '0; req_data = '0; rd_addr = '0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_write_two_phase();
        t_erase_one();
        t_status();
        t_gap();
        t_drops();
        t_global();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule